// File: doc/BRIEF.md
# Four-Queue FIFO with Dual-Mode Read Port

This block holds four independent first-in first-out queues in one shared storage array. A write port picks a target queue and pushes one word per clock. A read port picks a source queue with a 2-bit select. Each queue drives its own active-low read-side status flag. Reads, writes and flags all share one clock.

The read port works in one of two timing modes. The mode is captured from `mode_i` while `rst_ni` is low and is then kept until the next reset. In standard mode (`mode_i`=0) each flag is an empty indicator. A granted read loads the head word into an output register, and the word shows on the bus after that edge. In fall-through mode (`mode_i`=1) each queue prefetches its head word into a per-queue output stage, and the flag then reports that the output is ready. The bus shows the prefetched word of the queue chosen by a select that is delayed by two stages. The word therefore appears without any read, and a read consumes it.

Each queue holds DEPTH words in storage. DEPTH must be a power of two. In fall-through mode the queue holds one more word in its output stage.

Top module: `mq_fifo`

## Requirements
- R1: The mode is sampled from `mode_i` only while `rst_ni` is low. Changes on `mode_i` after reset alter neither flag meaning nor data behaviour.
- R2: Standard mode: `flag_n_o[q]` is 0 while queue q holds no readable word. A word written at edge E0 makes the flag 1 after edge E1, which is two register stages.
- R3: Standard mode: a read of a queue whose flag is 0 is ignored. `rd_data_o` and all stored words stay unchanged.
- R4: Standard mode: a granted read of queue `rd_q_i` puts that queue's oldest word on `rd_data_o` after the same edge, in write order.
- R5: Fall-through mode: a word written at edge E0 into an empty queue moves into that queue's output stage at edge E2, which is three register stages. The flag goes to 0 after E2, and the word is on the bus if that queue is displayed.
- R6: Fall-through mode: a read that moves the last stored word into the output stage leaves the flag at 0. A read with no stored word left sets the flag to 1 and leaves `rd_data_o` showing the last word.
- R7: Fall-through mode: reads of a queue whose flag is 1 are ignored until a new word arrives. That word then appears and the flag returns to 0.
- R8: Fall-through mode: when `rd_q_i` changes before edge A, `rd_data_o` shows the new queue's head word after edge A+1. This holds whatever the values of `rd_en_i` and `rd_cs_i`. Reads act on the displayed queue.
- R9: A read is granted only when `rd_en_i` and `rd_cs_i` are both 1.
- R10: A write to a queue that already holds DEPTH stored words is discarded. In standard mode exactly DEPTH words read back. In fall-through mode DEPTH+1 words read back, counting the output stage.
- R11: Activity on one queue never changes the flags of the other queues.
- R12: After reset `rd_data_o` is 0. All flags are 0 in standard mode and 1 in fall-through mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous master reset; samples the mode |
| mode_i | input | 1 | Mode select: 0 standard, 1 fall-through |
| wr_en_i | input | 1 | Write request |
| wr_q_i | input | 2 | Target queue of the write |
| wr_data_i | input | DW | Write word |
| rd_en_i | input | 1 | Read enable |
| rd_cs_i | input | 1 | Read chip select |
| rd_q_i | input | 2 | Read queue select |
| rd_data_o | output | DW | Read data bus |
| flag_n_o | output | 4 | Per-queue empty (standard) or not-ready (fall-through) flag, active low |

## Verification
The hardest state to reach is a full queue in fall-through mode. There, the number of writes that stick depends on the moment the prefetch pulls the first word out of storage. Two other corner cases matter: the drain read that leaves the bus holding a stale word, and a queue switch that happens while reads are pending. Directed sequences reach these cases with back-to-back write bursts past capacity, reads up to and beyond the last word, and select changes with the enables held. Seeded random traffic then mixes writes, reads, select changes and toggling of `mode_i` in both modes. A cycle model checks every flag and every bus value.

// File: rtl/mq_pkg.sv
package mq_pkg;
  parameter int unsigned NUM_Q = 4;
  localparam int unsigned QSEL_W = $clog2(NUM_Q);
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} rd_mode_e;
endpackage

// File: rtl/mq_store.sv
module mq_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned NQ    = 4,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned QW   = $clog2(NQ)
) (
  input  logic                   clk_i,
  input  logic                   we_i,
  input  logic [QW-1:0]          wq_i,
  input  logic [PW-1:0]          wptr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [NQ-1:0][PW-1:0]  rptr_i,
  output logic [NQ-1:0][DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [NQ*DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[{wq_i, wptr_i}] <= wdata_i;
  end

  // one region per queue, upper address bits are the queue index
  for (genvar g = 0; g < NQ; g++) begin : g_rd
    assign rdata_o[g] = mem[{QW'(g), rptr_i[g]}];
  end
endmodule

// File: rtl/mq_queue_ctrl.sv
module mq_queue_ctrl #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic [DW-1:0] rd_word_i,
  output logic          wr_acc_o,
  output logic          pop_o,
  output logic [PW-1:0] wptr_o,
  output logic [PW-1:0] rptr_o,
  output logic          flag_n_o,
  output logic [DW-1:0] head_o
);
  logic [CW-1:0] cnt_q;   // words in storage
  logic [CW-1:0] vis_q;   // words visible to the read side
  logic          stg_q;   // write-to-read visibility stage
  logic          hv_q;    // output stage holds a word (fall-through)
  logic [DW-1:0] head_q;
  logic [PW-1:0] wptr_q, rptr_q;
  logic full, vis_nz, std_rd, load, adv, drain, pop;

  always_comb begin
    full     = (cnt_q == CW'(DEPTH));
    wr_acc_o = wr_req_i & ~full;
    vis_nz   = (vis_q != '0);
    std_rd   = ~fwft_i & rd_req_i & vis_nz;
    load     =  fwft_i & ~hv_q & vis_nz;
    adv      =  fwft_i &  hv_q & rd_req_i & vis_nz;
    drain    =  fwft_i &  hv_q & rd_req_i & ~vis_nz;
    pop      = std_rd | load | adv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      vis_q  <= '0;
      stg_q  <= 1'b0;
      hv_q   <= 1'b0;
      head_q <= '0;
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      stg_q <= wr_acc_o;
      cnt_q <= cnt_q + CW'(wr_acc_o) - CW'(pop);
      vis_q <= vis_q + CW'(stg_q) - CW'(pop);
      if (wr_acc_o) wptr_q <= wptr_q + PW'(1);
      if (pop)      rptr_q <= rptr_q + PW'(1);
      if (load)       hv_q <= 1'b1;
      else if (drain) hv_q <= 1'b0;
      if (load | adv) head_q <= rd_word_i;
    end
  end

  assign pop_o    = pop;
  assign wptr_o   = wptr_q;
  assign rptr_o   = rptr_q;
  assign head_o   = head_q;
  assign flag_n_o = fwft_i ? ~hv_q : vis_nz;

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  a_r10_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && cnt_q == CW'(DEPTH)) |=> $stable(wptr_q));
  a_r2_vis_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_q <= cnt_q);
  a_r6_drain_holds_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_i && $fell(hv_q)) |-> $stable(head_q));
endmodule

// File: rtl/mq_fifo.sv
module mq_fifo
  import mq_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic                wr_en_i,
  input  logic [QSEL_W-1:0]   wr_q_i,
  input  logic [DW-1:0]       wr_data_i,
  input  logic                rd_en_i,
  input  logic                rd_cs_i,
  input  logic [QSEL_W-1:0]   rd_q_i,
  output logic [DW-1:0]       rd_data_o,
  output logic [NUM_Q-1:0]    flag_n_o
);
  rd_mode_e              mode_q;
  logic                  fwft;
  logic [QSEL_W-1:0]     sel1_q, sel2_q, rd_tgt;
  logic [DW-1:0]         dout_q;
  logic [NUM_Q-1:0]      wr_acc, pop, rd_req;
  logic [NUM_Q-1:0][PW-1:0] wptr, rptr;
  logic [NUM_Q-1:0][DW-1:0] rd_word, head;

  // mode follows mode_i only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= rd_mode_e'(mode_i);
  end
  assign fwft   = (mode_q == MODE_FWFT);
  assign rd_tgt = fwft ? sel2_q : rd_q_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel1_q <= '0;
      sel2_q <= '0;
      dout_q <= '0;
    end else begin
      sel1_q <= rd_q_i;
      sel2_q <= sel1_q;
      if (!fwft && pop[rd_q_i]) dout_q <= rd_word[rd_q_i];
    end
  end

  mq_store #(.DW(DW), .DEPTH(DEPTH), .NQ(NUM_Q)) u_store (
    .clk_i   (clk_i),
    .we_i    (|wr_acc),
    .wq_i    (wr_q_i),
    .wptr_i  (wptr[wr_q_i]),
    .wdata_i (wr_data_i),
    .rptr_i  (rptr),
    .rdata_o (rd_word)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    assign rd_req[g] = rd_en_i & rd_cs_i & (rd_tgt == QSEL_W'(g));
    mq_queue_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fwft_i    (fwft),
      .wr_req_i  (wr_en_i & (wr_q_i == QSEL_W'(g))),
      .rd_req_i  (rd_req[g]),
      .rd_word_i (rd_word[g]),
      .wr_acc_o  (wr_acc[g]),
      .pop_o     (pop[g]),
      .wptr_o    (wptr[g]),
      .rptr_o    (rptr[g]),
      .flag_n_o  (flag_n_o[g]),
      .head_o    (head[g])
    );
  end

  assign rd_data_o = fwft ? head[sel2_q] : dout_q;

  a_r1_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(mode_q));
  a_r3_std_bus_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft && !$stable(rd_data_o)) |-> $past(rd_en_i && rd_cs_i && flag_n_o[rd_q_i]));
  a_r10_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_acc));
  a_r9_no_pop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fwft && !(rd_en_i && rd_cs_i)) |-> (pop == '0));
endmodule

// File: tb/mq_fifo_tb_top.sv
module mq_fifo_tb_top;
  localparam int DW = 16;
  localparam int DEPTH = 8;

  logic clk_i = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rd_cs = 1'b0;
  logic [1:0] wr_q = '0, rd_q = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [3:0] flags;

  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  mq_fifo #(.DW(DW), .DEPTH(DEPTH)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_n), .mode_i(mode),
    .wr_en_i(wr_en), .wr_q_i(wr_q), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_cs_i(rd_cs), .rd_q_i(rd_q),
    .rd_data_o(rd_data), .flag_n_o(flags)
  );

  // cycle model built from the requirements
  bit            m_fwft;
  logic [DW-1:0] m_mem [4][DEPTH];
  int            m_wp[4], m_rp[4], m_cnt[4], m_vis[4];
  bit            m_pend[4], m_hv[4];
  logic [DW-1:0] m_head[4];
  logic [DW-1:0] m_dout;
  logic [1:0]    m_sel1, m_sel2;

  task automatic model_step();
    logic [DW-1:0] word[4];
    bit acc, rr, nz, pop, ld, adv, dr;
    logic [1:0] tgt;
    for (int q = 0; q < 4; q++) word[q] = m_mem[q][m_rp[q]];
    tgt = m_fwft ? m_sel2 : rd_q;
    for (int q = 0; q < 4; q++) begin
      acc = wr_en && (wr_q == 2'(q)) && (m_cnt[q] < DEPTH);
      rr  = rd_en && rd_cs && (tgt == 2'(q));
      nz  = m_vis[q] != 0;
      ld = 0; adv = 0; dr = 0;
      if (!m_fwft) begin
        pop = rr && nz;
        if (pop) m_dout = word[q];
      end else begin
        ld  = !m_hv[q] && nz;
        adv = m_hv[q] && rr && nz;
        dr  = m_hv[q] && rr && !nz;
        pop = ld || adv;
      end
      if (acc) begin
        m_mem[q][m_wp[q]] = wr_data;
        m_wp[q] = (m_wp[q] + 1) % DEPTH;
      end
      m_vis[q] = m_vis[q] + int'(m_pend[q]) - int'(pop);
      m_cnt[q] = m_cnt[q] + int'(acc) - int'(pop);
      m_pend[q] = acc;
      if (pop) m_rp[q] = (m_rp[q] + 1) % DEPTH;
      if (ld || adv) m_head[q] = word[q];
      if (ld) m_hv[q] = 1;
      else if (dr) m_hv[q] = 0;
    end
    m_sel2 = m_sel1;
    m_sel1 = rd_q;
  endtask

  always @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      m_fwft = mode;
      for (int q = 0; q < 4; q++) begin
        m_wp[q] = 0; m_rp[q] = 0; m_cnt[q] = 0; m_vis[q] = 0;
        m_pend[q] = 0; m_hv[q] = 0; m_head[q] = '0;
      end
      m_dout = '0; m_sel1 = '0; m_sel2 = '0;
    end else begin
      model_step();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_flags();
    logic [3:0] f;
    for (int q = 0; q < 4; q++) f[q] = m_fwft ? !m_hv[q] : (m_vis[q] != 0);
    return f;
  endfunction

  always @(negedge clk_i) begin
    if (rst_n) begin
      check(flags == exp_flags(), "R11 per-queue flags", flags, exp_flags());
      if (m_fwft) check(rd_data == m_head[m_sel2], "R6 fall-through bus", rd_data, m_head[m_sel2]);
      else        check(rd_data == m_dout, "R4 standard bus", rd_data, m_dout);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; rd_cs = 0;
  endtask

  task automatic wr(input logic [1:0] q, input logic [DW-1:0] d);
    wr_en = 1; wr_q = q; wr_data = d; step(1); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] q);
    rd_en = 1; rd_cs = 1; rd_q = q; step(1); rd_en = 0; rd_cs = 0;
  endtask

  task automatic do_reset(input bit m);
    idle(); mode = m; rd_q = '0;
    rst_n = 0; step(3); rst_n = 1;
  endtask

  initial begin
    #1_900_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'h5EED_1234));
    // ---------------- standard mode ----------------
    @(negedge clk_i);
    do_reset(0);
    check(flags == 4'b0000, "R12 std flags", flags, 0);
    check(rd_data == '0, "R12 std bus", rd_data, 0);
    wr(1, 16'h1A1A);
    check(flags[1] == 0, "R2 flag still low after E0", flags[1], 0);
    step(1);
    check(flags[1] == 1, "R2 flag high after E1", flags[1], 1);
    check(flags[0] == 0 && flags[2] == 0 && flags[3] == 0, "R11 others empty", flags, 4'b0010);
    rd(2);
    check(rd_data == '0, "R3 empty read ignored", rd_data, 0);
    rd_q = 1; rd_en = 1; rd_cs = 0; step(1); idle();
    check(rd_data == '0 && flags[1], "R9 no chip select", rd_data, 0);
    rd_en = 0; rd_cs = 1; step(1); idle();
    check(rd_data == '0 && flags[1], "R9 no enable", rd_data, 0);
    rd(1);
    check(rd_data == 16'h1A1A, "R4 read word", rd_data, 16'h1A1A);
    check(flags[1] == 0, "R4 queue empty again", flags[1], 0);
    mode = 1;
    wr(0, 16'h0B0B); step(1);
    check(flags[3] == 0, "R1 empty meaning kept", flags[3], 0);
    rd(0);
    check(rd_data == 16'h0B0B, "R1 standard read kept", rd_data, 16'h0B0B);
    mode = 0;
    for (int i = 0; i < DEPTH + 2; i++) wr(3, DW'(16'h3000 + i));
    step(3);
    k = 0;
    while (flags[3] && k < 20) begin
      rd(3);
      check(rd_data == DW'(16'h3000 + k), "R10 std full order", rd_data, 16'h3000 + k);
      k++;
    end
    check(k == DEPTH, "R10 std stored count", k, DEPTH);

    // ---------------- fall-through mode ----------------
    do_reset(1);
    check(flags == 4'b1111, "R12 fwft flags", flags, 4'hF);
    check(rd_data == '0, "R12 fwft bus", rd_data, 0);
    rd_q = 2; step(2);
    wr(2, 16'h2C2C);
    check(flags[2] == 1, "R5 not ready after E0", flags[2], 1);
    step(1);
    check(flags[2] == 1, "R5 not ready after E1", flags[2], 1);
    step(1);
    check(flags[2] == 0, "R5 ready after E2", flags[2], 0);
    check(rd_data == 16'h2C2C, "R5 word falls through", rd_data, 16'h2C2C);
    wr(2, 16'h2D2D); step(3);
    rd(2);
    check(rd_data == 16'h2D2D && flags[2] == 0, "R6 last word keeps ready", rd_data, 16'h2D2D);
    rd(2);
    check(flags[2] == 1, "R6 drain read raises flag", flags[2], 1);
    check(rd_data == 16'h2D2D, "R6 last word held", rd_data, 16'h2D2D);
    rd(2);
    check(rd_data == 16'h2D2D && flags[2] == 1, "R7 read while not ready", rd_data, 16'h2D2D);
    wr(2, 16'h2E2E); step(3);
    check(rd_data == 16'h2E2E && flags[2] == 0, "R7 new word presented", rd_data, 16'h2E2E);
    wr(0, 16'h0F0F); step(3);
    rd_q = 0; rd_en = 1; rd_cs = 0; step(1);
    check(rd_data == 16'h2E2E, "R8 old queue after one edge", rd_data, 16'h2E2E);
    step(1); idle();
    check(rd_data == 16'h0F0F, "R8 new head after two edges", rd_data, 16'h0F0F);
    rd_q = 1; step(2);
    for (int i = 0; i < DEPTH + 3; i++) wr(1, DW'(16'h1000 + i));
    step(4);
    k = 0;
    while (!flags[1] && k < 20) begin
      check(rd_data == DW'(16'h1000 + k), "R10 fwft full order", rd_data, 16'h1000 + k);
      rd(1);
      k++;
    end
    check(k == DEPTH + 1, "R10 fwft stored count", k, DEPTH + 1);

    // ---------------- seeded random traffic ----------------
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      for (int c = 0; c < 3000; c++) begin
        wr_en   = ($urandom % 2) == 0;
        wr_q    = (($urandom % 3) == 0) ? 2'd3 : 2'($urandom % 4);
        wr_data = DW'($urandom);
        rd_en   = ($urandom % 3) == 0;
        rd_cs   = ($urandom % 4) != 0;
        if (($urandom % 8) == 0) rd_q = 2'($urandom % 4);
        mode    = ($urandom % 2) == 1; // R1: ignored after reset
        step(1);
      end
      idle(); step(2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule